// File: doc/BRIEF.md
# Byte SPI Master with Two-Deep Transmit and Receive Staging

This block is a byte-wide serial master. Software or an upstream stream source hands it bytes over a valid/ready transmit port. Each accepted byte is shifted out on `mosi` while `miso` is sampled, so every byte sent returns exactly one byte. Two transmit slots let a second byte be queued while the first is still shifting, so bytes go out in a continuous stream.

Returned bytes land in a visible receive stage that is presented on a valid/ready receive port. A hidden holding stage sits behind it. When the consumer takes the visible byte, a held byte moves forward on the same clock edge. A one-cycle `rx_event` pulse marks every byte that becomes visible, including the bytes that move forward from the holding stage.

Back-pressure works as follows. The transmit port accepts a byte on any rising edge where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low while the block is disabled or both transmit slots are occupied. On the receive side, `rx_data` must stay put until a rising edge sees `rx_valid` and `rx_ready` both high. If both receive stages are full, the master waits before starting the next byte, so no received byte is ever lost. Clock polarity, sampling phase, bit order and the divisor should be changed only while no transfer is in progress.

Top module: `spi_byte_master`

## Requirements
- R1: While `enable` is high and no byte is shifting, a byte accepted on the transmit port starts a transfer: `sck` begins toggling without any further action.
- R2: The transmit path holds two bytes. Two bytes can be accepted on consecutive clock cycles. `tx_ready` is low whenever both transmit slots are occupied.
- R3: Bytes appear on `mosi` in exactly the order in which the transmit port accepted them.
- R4: For every byte shifted out, one byte is captured from `miso`. The captured bytes are delivered on the receive port in the order they were captured.
- R5: While `rx_valid` is high and `rx_ready` is low, `rx_valid` and `rx_data` hold steady. When a byte waits in the holding stage, the byte that follows a read is visible in the very next cycle.
- R6: `rx_event` is high for one cycle each time a byte enters the visible receive stage, in the first cycle that byte is shown with `rx_valid` high. This includes a move from the holding stage.
- R7: When both transmit slots are empty after a byte completes, the master stops. While stopped, `sck` equals `cpol` and `mosi` is 0.
- R8: With `cpha`=0, `miso` is sampled on the first `sck` edge of each bit and `mosi` changes on the second edge. With `cpha`=1, `mosi` changes on the first edge and sampling takes place on the second edge.
- R9: With `lsb_first`=0, bit 7 is shifted first. With `lsb_first`=1, bit 0 is shifted first. The same order applies to sending and to receiving.
- R10: Within a byte, consecutive `sck` edges are `clk_div`+1 system clock cycles apart. The `sck` period is therefore 2*(`clk_div`+1) cycles.
- R11: If both receive stages are full, no new byte starts until the consumer reads the visible stage.
- R12: While `enable` is low, `tx_ready` is low, no byte starts, and `sck` and `mosi` stay at their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Allows bytes to be accepted and started |
| cpol | input | 1 | Idle level of `sck` |
| cpha | input | 1 | 0: sample on the first edge of a bit; 1: sample on the second edge |
| lsb_first | input | 1 | 1: bit 0 is shifted first; 0: bit 7 is shifted first |
| clk_div | input | DIV_W | Half period of `sck` minus one, in system cycles |
| tx_valid | input | 1 | A transmit byte is offered |
| tx_ready | output | 1 | The transmit port can take a byte |
| tx_data | input | W | Transmit byte |
| rx_valid | output | 1 | The visible receive stage holds a byte |
| rx_ready | input | 1 | The consumer takes the visible byte |
| rx_data | output | W | Visible received byte |
| rx_event | output | 1 | One-cycle pulse when a byte becomes visible |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with W=8 and DIV_W=8, and drives `clk_div` between 1 and 3. This keeps each byte under about a hundred cycles, so all four clock modes can be run in both bit orders. An SPI slave model in the bench checks edge spacing, the sampling edge and the bit order independently. Directed runs that never read the receive port fill both receive stages and both transmit slots, which exercises the stall and the forward move from the holding stage. A run with `enable` low confirms that the pins stay quiet.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_DONE = 2'd2
  } eng_state_e;

endpackage

// File: rtl/spi_tx_slots.sv
module spi_tx_slots #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         avail,
  output logic         full
);

  logic [W-1:0] slot0, slot1;
  logic [1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0 <= '0;
      slot1 <= '0;
      cnt   <= 2'd0;
    end else begin
      unique case ({push, pop})
        2'b01: begin
          slot0 <= slot1;
          cnt   <= cnt - 2'd1;
        end
        2'b10: begin
          if (cnt == 2'd0) slot0 <= push_data;
          else             slot1 <= push_data;
          cnt <= cnt + 2'd1;
        end
        2'b11: begin
          // pop needs one entry, push needs a free one: count is 1 here
          slot0 <= push_data;
        end
        default: ;
      endcase
    end
  end

  assign head  = slot0;
  assign avail = (cnt != 2'd0);
  assign full  = (cnt == 2'd2);

endmodule

// File: rtl/spi_rx_stages.sv
module spi_rx_stages #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         take,
  output logic         vis_valid,
  output logic [W-1:0] vis_data,
  output logic         hold_valid,
  output logic         new_vis
);

  logic [W-1:0] hold_data;
  logic         pop;

  assign pop = take && vis_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_valid  <= 1'b0;
      vis_data   <= '0;
      hold_valid <= 1'b0;
      hold_data  <= '0;
      new_vis    <= 1'b0;
    end else begin
      new_vis <= 1'b0;
      if (pop) begin
        if (hold_valid) begin
          vis_data <= hold_data;
          new_vis  <= 1'b1;
          if (push) hold_data  <= push_data;
          else      hold_valid <= 1'b0;
        end else if (push) begin
          vis_data <= push_data;
          new_vis  <= 1'b1;
        end else begin
          vis_valid <= 1'b0;
        end
      end else if (push) begin
        if (!vis_valid) begin
          vis_valid <= 1'b1;
          vis_data  <= push_data;
          new_vis   <= 1'b1;
        end else begin
          hold_valid <= 1'b1;
          hold_data  <= push_data;
        end
      end
    end
  end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_master_pkg::*;
#(
  parameter int W     = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             tx_avail,
  input  logic [W-1:0]     tx_head,
  output logic             tx_pop,
  input  logic             rx_blocked,
  output logic             rx_push,
  output logic [W-1:0]     rx_byte,
  output logic             busy,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);

  localparam int EDGES = 2 * W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  eng_state_e       state;
  logic [DIV_W-1:0] hc;
  logic [EW-1:0]    ec;
  logic [W-1:0]     tx_sr, rx_sr, load_byte;
  logic             sck_r, mosi_r;
  logic             tick, leading, sample_edge, last_edge, start;

  function automatic logic [W-1:0] flip(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  assign start       = (state == ENG_IDLE) && enable && tx_avail && !rx_blocked;
  assign tx_pop      = start;
  assign load_byte   = lsb_first ? flip(tx_head) : tx_head;
  assign tick        = (hc == clk_div);
  assign leading     = ~ec[0];
  assign sample_edge = cpha ? ~leading : leading;
  assign last_edge   = (ec == LAST_EDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ENG_IDLE;
      hc     <= '0;
      ec     <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      sck_r  <= 1'b0;
      mosi_r <= 1'b0;
    end else begin
      unique case (state)
        ENG_IDLE: begin
          if (start) begin
            state <= ENG_RUN;
            hc    <= '0;
            ec    <= '0;
            sck_r <= cpol;
            if (!cpha) begin
              mosi_r <= load_byte[W-1];
              tx_sr  <= load_byte << 1;
            end else begin
              mosi_r <= 1'b0;
              tx_sr  <= load_byte;
            end
          end
        end
        ENG_RUN: begin
          if (tick) begin
            hc    <= '0;
            ec    <= ec + 1'b1;
            sck_r <= ~sck_r;
            if (sample_edge) begin
              rx_sr <= {rx_sr[W-2:0], miso};
            end else if (!last_edge) begin
              mosi_r <= tx_sr[W-1];
              tx_sr  <= tx_sr << 1;
            end
            if (last_edge) state <= ENG_DONE;
          end else begin
            hc <= hc + 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign rx_push = (state == ENG_DONE);
  assign rx_byte = lsb_first ? flip(rx_sr) : rx_sr;
  assign busy    = (state != ENG_IDLE);
  assign sck     = busy ? sck_r : cpol;
  assign mosi    = busy & mosi_r;

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int W     = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [W-1:0]     tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [W-1:0]     rx_data,
  output logic             rx_event,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);

  logic         tx_push, tx_pop, tx_avail, tx_full;
  logic [W-1:0] tx_head;
  logic         rx_push, rx_hold_valid, rx_blocked, eng_busy;
  logic [W-1:0] rx_byte;

  assign tx_ready   = enable && !tx_full;
  assign tx_push    = tx_valid && tx_ready;
  assign rx_blocked = rx_valid && rx_hold_valid;

  spi_tx_slots #(.W(W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (tx_push),
    .push_data (tx_data),
    .pop       (tx_pop),
    .head      (tx_head),
    .avail     (tx_avail),
    .full      (tx_full)
  );

  spi_shift_engine #(.W(W), .DIV_W(DIV_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cpol       (cpol),
    .cpha       (cpha),
    .lsb_first  (lsb_first),
    .clk_div    (clk_div),
    .tx_avail   (tx_avail),
    .tx_head    (tx_head),
    .tx_pop     (tx_pop),
    .rx_blocked (rx_blocked),
    .rx_push    (rx_push),
    .rx_byte    (rx_byte),
    .busy       (eng_busy),
    .sck        (sck),
    .mosi       (mosi),
    .miso       (miso)
  );

  spi_rx_stages #(.W(W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (rx_push),
    .push_data  (rx_byte),
    .take       (rx_ready),
    .vis_valid  (rx_valid),
    .vis_data   (rx_data),
    .hold_valid (rx_hold_valid),
    .new_vis    (rx_event)
  );

endmodule

// File: rtl/spi_byte_master_checker.sv
module spi_byte_master_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         tx_ready,
  input logic         tx_full,
  input logic         tx_avail,
  input logic         eng_busy,
  input logic         rx_push,
  input logic         rx_hold_valid,
  input logic         rx_valid,
  input logic         rx_ready,
  input logic [W-1:0] rx_data,
  input logic         rx_event
);

  assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_ready);

  // R1 as well: a start needs a queued byte
  assert_start_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> ($past(enable) && $past(tx_avail)));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_hold_valid);

  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_event_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |-> rx_valid);

endmodule

bind spi_byte_master spi_byte_master_checker #(.W(W)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .tx_ready      (tx_ready),
  .tx_full       (tx_full),
  .tx_avail      (tx_avail),
  .eng_busy      (eng_busy),
  .rx_push       (rx_push),
  .rx_hold_valid (rx_hold_valid),
  .rx_valid      (rx_valid),
  .rx_ready      (rx_ready),
  .rx_data       (rx_data),
  .rx_event      (rx_event)
);

// File: tb/spi_byte_master_bench.sv
`timescale 1ns/1ps
module spi_byte_master_bench;

  localparam int W     = 8;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb = 1'b0;
  logic [DIV_W-1:0] cfg_div = 8'd1;
  logic tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0, rx_event;
  logic [W-1:0] tx_data = '0, rx_data;
  logic sck, mosi, miso;

  int checks = 0, errors = 0;
  int cyc = 0, last_cyc = 0;
  int rdmode = 1, rcv_n = 0, ev_cnt = 0, s_n = 0, s_e = 0;
  int acc_cyc = 0;
  logic [2:0] s_bits = 3'd0;
  logic [7:0] s_cur = 8'd0, s_rx = 8'd0;
  logic sck_d = 1'b0;
  logic [7:0] exp_tx[$];
  bit held = 0, chk_next = 0;
  logic [7:0] held_data = 8'd0;

  always #4 clk = ~clk;

  spi_byte_master #(.W(W), .DIV_W(DIV_W)) u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .lsb_first(cfg_lsb), .clk_div(cfg_div), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_event(rx_event), .sck(sck), .mosi(mosi), .miso(miso)
  );

  function automatic logic [7:0] slave_byte(input int k);
    return 8'(((k * 73) + 29) ^ (k >> 2));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      chk(1'b0, "R7 watchdog expired", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // slave model: drives miso from its own byte sequence, samples mosi on its own edge choice
  assign miso = cfg_lsb ? s_cur[s_bits] : s_cur[3'd7 - s_bits];

  always @(posedge clk) begin
    logic lead, samp;
    logic [7:0] nrx;
    if (!rst_n) begin
      sck_d  <= cfg_cpol;
      s_bits <= 3'd0;
      s_n    <= 0;
      s_e    <= 0;
      s_cur  <= slave_byte(0);
    end else if (sck !== sck_d) begin
      sck_d <= sck;
      if (s_e != 0) chk(cyc - last_cyc == int'(cfg_div) + 1, "R10 edge spacing", cyc - last_cyc, int'(cfg_div) + 1);
      last_cyc <= cyc;
      s_e <= (s_e == 15) ? 0 : s_e + 1;
      lead = (sck != cfg_cpol);
      samp = cfg_cpha ? !lead : lead;
      if (samp) begin
        nrx = cfg_lsb ? {mosi, s_rx[7:1]} : {s_rx[6:0], mosi};
        s_rx <= nrx;
        if (s_bits == 3'd7) begin
          if (s_n < exp_tx.size())
            chk(nrx == exp_tx[s_n], "R3 R8 R9 mosi byte", nrx, exp_tx[s_n]);
          else
            chk(1'b0, "R3 unexpected byte", nrx, 0);
          s_n    <= s_n + 1;
          s_cur  <= slave_byte(s_n + 1);
          s_bits <= 3'd0;
        end else begin
          s_bits <= s_bits + 3'd1;
        end
      end
    end
  end

  // receive consumer
  always @(negedge clk) begin
    if (!rst_n) begin
      held = 0;
      chk_next = 0;
    end else begin
      if (rx_event) begin
        ev_cnt++;
        chk(rx_valid == 1'b1, "R6 event with visible byte", rx_valid, 1);
      end
      if (held)
        chk(rx_valid && rx_data == held_data, "R5 held byte stable", rx_data, held_data);
      if (chk_next) begin
        chk(rx_valid && rx_data == slave_byte(rcv_n), "R5 held byte moved forward", rx_data, slave_byte(rcv_n));
        chk_next = 0;
      end
      case (rdmode)
        0: rx_ready = 1'b0;
        1: rx_ready = 1'b1;
        3: rx_ready = 1'b1;
        default: rx_ready = ($urandom % 3) == 0;
      endcase
      held = 0;
      if (rx_valid) begin
        if (rx_ready) begin
          chk(rx_data == slave_byte(rcv_n), "R4 received byte", rx_data, slave_byte(rcv_n));
          rcv_n++;
          if (rdmode == 3) begin
            rdmode = 0;
            chk_next = 1;
          end
        end else begin
          held = 1;
          held_data = rx_data;
        end
      end else if (rdmode == 3) begin
        rx_ready = 1'b0;
      end
    end
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    while (!tx_ready) @(negedge clk);
    exp_tx.push_back(b);
    acc_cyc = cyc;
    @(posedge clk);
  endtask

  task automatic tx_off();
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic start_phase(input bit pol, input bit pha, input bit lsb, input int div, input int mode);
    @(negedge clk);
    rst_n = 1'b0;
    tx_valid = 1'b0;
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb = lsb; cfg_div = DIV_W'(div);
    enable = 1'b1;
    rdmode = mode;
    exp_tx.delete();
    rcv_n = 0; ev_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_valid == 1'b0 && rx_event == 1'b0, "R7 reset receive state", rx_valid, 0);
    chk(sck == pol && mosi == 1'b0, "R7 reset pins", {sck, mosi}, {pol, 1'b0});
  endtask

  task automatic finish_phase(input int n);
    int t = 0;
    while (rcv_n < n && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(rcv_n == n, "R4 all bytes returned", rcv_n, n);
    chk(s_n == n, "R1 R3 bytes seen by slave", s_n, n);
    chk(ev_cnt == n, "R6 one event per byte", ev_cnt, n);
    repeat (2 * (int'(cfg_div) + 1) + 4) begin
      @(negedge clk);
      chk(sck == cfg_cpol && mosi == 1'b0, "R7 idle pins after stop", {sck, mosi}, {cfg_cpol, 1'b0});
    end
  endtask

  initial begin
    void'($urandom(32'd4242));

    // directed: back-to-back acceptance, MSB first, mode 0
    start_phase(1'b0, 1'b0, 1'b0, 1, 1);
    begin
      int a1;
      put(8'hA5);
      a1 = acc_cyc;
      put(8'h3C);
      chk(acc_cyc - a1 == 1, "R2 consecutive acceptance", acc_cyc - a1, 1);
    end
    put(8'h00);
    put(8'hFF);
    tx_off();
    finish_phase(4);

    // random sweep over all clock modes and both bit orders
    for (int m = 0; m < 8; m++) begin
      int n = 10;
      start_phase(m[0], m[1], m[2], 1 + (m % 3), 2);
      for (int i = 0; i < n; i++) begin
        put(8'($urandom));
        if (($urandom % 4) == 0) begin
          tx_off();
          repeat ($urandom % 40) @(negedge clk);
        end
      end
      tx_off();
      finish_phase(n);
    end

    // stall: nobody reads, both receive stages and both transmit slots fill
    start_phase(1'b1, 1'b1, 1'b0, 2, 0);
    put(8'h11); put(8'h22); put(8'h33); put(8'h44);
    tx_off();
    repeat (400) @(negedge clk);
    chk(s_n == 2, "R11 stall with receive stages full", s_n, 2);
    chk(tx_ready == 1'b0, "R2 tx_ready low with both slots full", tx_ready, 0);
    chk(rx_valid && rx_data == slave_byte(0), "R5 first byte still visible", rx_data, slave_byte(0));
    chk(sck == 1'b1 && mosi == 1'b0, "R7 pins idle during stall", {sck, mosi}, 2'b10);
    rdmode = 3;
    repeat (4) @(negedge clk);
    rdmode = 1;
    finish_phase(4);

    // disabled: offered byte is never taken and the pins stay idle
    start_phase(1'b1, 1'b0, 1'b1, 1, 1);
    enable = 1'b0;
    tx_valid = 1'b1;
    tx_data = 8'h5A;
    repeat (60) begin
      @(negedge clk);
      chk(tx_ready == 1'b0, "R12 tx_ready low when disabled", tx_ready, 0);
      chk(sck == 1'b1 && mosi == 1'b0, "R12 pins idle when disabled", {sck, mosi}, 2'b10);
    end
    chk(s_n == 0 && rx_valid == 1'b0, "R12 no transfer when disabled", s_n, 0);
    tx_valid = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule